// File: doc/BRIEF.md
# Programmable Eight-Input Interrupt Controller

This block gathers eight interrupt request lines, decides which of them should interrupt a processor, and presents one interrupt output. Each input is captured either on a rising edge or as a level, selected per input by a trigger-mode vector. Software programs the unit through a byte-wide port with a one-bit address. An initialisation sequence sets the vector base and operating options. After it, commands handle end of interrupt, priority rotation, register readback and polling. Pending requests can be masked individually.

When the output is high, the processor pulses the acknowledge input. The block then presents an 8-bit vector made of the programmed base and the winning level. It also moves that level into service. A polled read can stand in for the acknowledge. The priority order is circular, and a movable rotation base selects which level currently ranks highest. Each priority pick is made by a separate resolver instance.

Top module: `prio_intc`

## Requirements
- R1: An input whose trigger-mode bit is 1 is level captured. Its request bit equals the input value sampled at the previous clock edge, and acknowledge does not clear it.
- R2: An input whose trigger-mode bit is 0 is edge captured. Its request bit is set when the input goes from low to high between two clock edges. A steady high input sets nothing more. Acknowledge clears the bit.
- R3: A write to address 0 with data bit 4 set starts initialisation. It clears the request, in-service and mask registers, the rotation base and all options, and it records data bit 0 as the "fourth word follows" flag. The next address-1 write sets the vector base to its data with bits 2:0 forced to zero.
- R4: After the vector base, one more address-1 write is consumed. A fourth word follows only when the flag is set. Address-1 writes after that load the mask register.
- R5: Priority order is circular. With rotation base b, level (b+k) mod 8 has rank k, and rank 0 is the highest. After initialisation b is 0. The output is high when the best unmasked pending request ranks strictly above the best in-service level.
- R6: On acknowledge while the output is high, the vector is the base OR the winning level, and that level's in-service bit is set. When the output is low, the vector is the base OR 7 and no state changes.
- R7: A fourth word with bit 1 set selects auto end of interrupt. In that mode, acknowledge sets no in-service bit. When rotate-on-auto-EOI is set, acknowledge moves the rotation base to the winning level plus 1. Writing an address-0 command with bits 7:5 equal to 000 or 100 loads rotate-on-auto-EOI from bit 7.
- R8: Address-0 commands with bits 4:3 equal to 00 decode bits 7:5 as follows:
  - 001 clears the highest-ranked in-service bit.
  - 101 clears the highest-ranked in-service bit and sets the rotation base to that level plus 1.
  - 011 clears the in-service bit named by bits 2:0.
  - 111 clears the named bit and sets the rotation base to that level plus 1.
  - 110 sets the rotation base to bits 2:0 plus 1.
  - 010 does nothing.
- R9: An address-0 write with bit 4 = 0 and bit 3 = 1 is a read command. When its bit 1 is set, bit 0 selects what address-0 reads return: 1 for the in-service register, 0 for the request register. Address-1 reads return the mask register.
- R10: A read command with bit 2 set arms poll. The next read returns the winning level in bits 2:0, or 7 when the output is low. It clears that level's request and in-service bits and then disarms poll.
- R11: A read command with bit 6 set loads special mask from bit 5. With special mask on, masked in-service levels do not block lower-ranked requests.
- R12: A fourth word with bit 4 set selects special nesting. In that mode the in-service bit of input 2 is left out of the blocking comparison, so a new request on input 2 can interrupt while input 2 is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 1 | Register port address |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| irq_in | input | 8 | Interrupt request lines |
| trig_lvl | input | 8 | Per-input trigger mode, 1 = level |
| int_out | output | 1 | Interrupt output to the processor |
| ack | input | 1 | Acknowledge strobe |
| ack_vec | output | 8 | Vector presented during acknowledge |

## Verification
The main function is tried with these request patterns:
- Single edges, to confirm that edges are captured.
- Held levels, which show the difference between edge and level capture, because an acknowledge clears only the edge-captured request.
- Two simultaneous requests, which show whether the resolver picks the higher rank.
- A higher request arriving while a lower one is in service, which separates pending priority from in-service blocking.
- Requests placed around a moved rotation base, which catch a resolver that ignores rotation.
- Requests made while masked or under special mask, and while the cascade input is in service under special nesting, which separate the three blocking rules from one another.

// File: rtl/prio_intc.sv
module prio_intc_pick (
  input  logic [7:0] req,
  input  logic [2:0] base,
  output logic       hit,
  output logic [2:0] lvl,
  output logic [3:0] rank
);
  always_comb begin
    hit  = |req;
    lvl  = 3'd0;
    rank = 4'd8;
    for (int k = 7; k >= 0; k--) begin
      if (req[base + k[2:0]]) begin
        lvl  = base + k[2:0];
        rank = k[3:0];
      end
    end
  end
endmodule

module prio_intc #(
  parameter int CASC_IN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  input  logic [7:0] trig_lvl,
  output logic       int_out,
  input  logic       ack,
  output logic [7:0] ack_vec
);
  localparam logic [7:0] CASC_BIT = 8'(1) << CASC_IN;

  logic [7:0] irr_q, isr_q, imr_q, last_q;
  logic [7:0] irr_n, isr_n, imr_n;
  logic [4:0] base_q, base_n;
  logic [2:0] rot_q, rot_n;
  logic [1:0] st_q, st_n;
  logic icw4_q, aeoi_q, raeoi_q, sfnm_q, rsel_q, poll_q, smm_q;
  logic icw4_n, aeoi_n, raeoi_n, sfnm_n, rsel_n, poll_n, smm_n;

  logic [7:0] pend_req, cur_req;
  logic       pend_hit, cur_hit, eoi_hit;
  logic [2:0] pend_lvl, cur_lvl, eoi_lvl;
  logic [3:0] pend_rank, cur_rank, eoi_rank;

  assign pend_req = irr_q & ~imr_q;
  assign cur_req  = isr_q & ~(smm_q ? imr_q : 8'h00) & ~(sfnm_q ? CASC_BIT : 8'h00);

  prio_intc_pick pend_p (.req(pend_req), .base(rot_q), .hit(pend_hit), .lvl(pend_lvl), .rank(pend_rank));
  prio_intc_pick cur_p  (.req(cur_req),  .base(rot_q), .hit(cur_hit),  .lvl(cur_lvl),  .rank(cur_rank));
  prio_intc_pick eoi_p  (.req(isr_q),    .base(rot_q), .hit(eoi_hit),  .lvl(eoi_lvl),  .rank(eoi_rank));

  logic [2:0] win;
  assign int_out = pend_hit && (pend_rank < cur_rank);
  assign win     = int_out ? pend_lvl : 3'd7;
  assign ack_vec = {base_q, win};
  assign rdata   = poll_q ? {5'd0, win} : (addr ? imr_q : (rsel_q ? isr_q : irr_q));

  logic is_init, is_rdcmd, is_cmd, is_cfg;
  assign is_init  = wr_en && !addr && wdata[4];
  assign is_rdcmd = wr_en && !addr && !wdata[4] && wdata[3];
  assign is_cmd   = wr_en && !addr && !wdata[4] && !wdata[3];
  assign is_cfg   = wr_en && addr;

  always_comb begin
    irr_n = irr_q;  isr_n = isr_q;  imr_n = imr_q;
    base_n = base_q;  rot_n = rot_q;  st_n = st_q;
    icw4_n = icw4_q;  aeoi_n = aeoi_q;  raeoi_n = raeoi_q;  sfnm_n = sfnm_q;
    rsel_n = rsel_q;  poll_n = poll_q;  smm_n = smm_q;

    if (ack && int_out) begin
      if (aeoi_q) begin
        if (raeoi_q) rot_n = pend_lvl + 3'd1;
      end else begin
        isr_n[pend_lvl] = 1'b1;
      end
      if (!trig_lvl[pend_lvl]) irr_n[pend_lvl] = 1'b0;
    end

    if (rd_en && poll_q) begin
      if (int_out) begin
        irr_n[pend_lvl] = 1'b0;
        isr_n[pend_lvl] = 1'b0;
      end
      poll_n = 1'b0;
    end

    if (is_init) begin
      irr_n = '0;  isr_n = '0;  imr_n = '0;  base_n = '0;  rot_n = '0;
      aeoi_n = 1'b0;  raeoi_n = 1'b0;  sfnm_n = 1'b0;
      rsel_n = 1'b0;  poll_n = 1'b0;  smm_n = 1'b0;
      icw4_n = wdata[0];
      st_n = 2'd1;
    end else if (is_rdcmd) begin
      if (wdata[2]) poll_n = 1'b1;
      if (wdata[1]) rsel_n = wdata[0];
      if (wdata[6]) smm_n  = wdata[5];
    end else if (is_cmd) begin
      case (wdata[7:5])
        3'd0, 3'd4: raeoi_n = wdata[7];
        3'd1, 3'd5: if (eoi_hit) begin
          isr_n[eoi_lvl] = 1'b0;
          if (wdata[7]) rot_n = eoi_lvl + 3'd1;
        end
        3'd3: isr_n[wdata[2:0]] = 1'b0;
        3'd6: rot_n = wdata[2:0] + 3'd1;
        3'd7: begin
          isr_n[wdata[2:0]] = 1'b0;
          rot_n = wdata[2:0] + 3'd1;
        end
        default: ;
      endcase
    end else if (is_cfg) begin
      case (st_q)
        2'd0: imr_n = wdata;
        2'd1: begin
          base_n = wdata[7:3];
          st_n = 2'd2;
        end
        2'd2: st_n = icw4_q ? 2'd3 : 2'd0;
        default: begin
          sfnm_n = wdata[4];
          aeoi_n = wdata[1];
          st_n = 2'd0;
        end
      endcase
    end

    irr_n = ((irr_n | (irq_in & ~last_q)) & ~trig_lvl) | (irq_in & trig_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q <= '0;  isr_q <= '0;  imr_q <= '0;  last_q <= '0;
      base_q <= '0;  rot_q <= '0;  st_q <= '0;
      icw4_q <= 1'b0;  aeoi_q <= 1'b0;  raeoi_q <= 1'b0;  sfnm_q <= 1'b0;
      rsel_q <= 1'b0;  poll_q <= 1'b0;  smm_q <= 1'b0;
    end else begin
      irr_q <= irr_n;  isr_q <= isr_n;  imr_q <= imr_n;  last_q <= irq_in;
      base_q <= base_n;  rot_q <= rot_n;  st_q <= st_n;
      icw4_q <= icw4_n;  aeoi_q <= aeoi_n;  raeoi_q <= raeoi_n;  sfnm_q <= sfnm_n;
      rsel_q <= rsel_n;  poll_q <= poll_n;  smm_q <= smm_n;
    end
  end
endmodule

module prio_intc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic [7:0] irq_in,
  input logic [7:0] trig_lvl,
  input logic       ack,
  input logic       int_out,
  input logic [7:0] ack_vec,
  input logic [7:0] irr_q,
  input logic [7:0] isr_q,
  input logic [7:0] imr_q,
  input logic       poll_q,
  input logic       aeoi_q
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((irr_q ^ $past(irq_in)) & $past(trig_lvl)) == 8'h00); // R1
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (isr_q == 8'h00 && imr_q == 8'h00)); // R3
  AST_OUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr_q & ~imr_q) != 8'h00); // R5
  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out && !aeoi_q && !wr_en && !rd_en) |=> isr_q[$past(ack_vec[2:0])]); // R6
  AST_AEOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out && aeoi_q && !wr_en && !rd_en) |=> isr_q == $past(isr_q)); // R7
  AST_POLL_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll_q && !wr_en) |=> !poll_q); // R10
endmodule

bind prio_intc prio_intc_chk chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .irq_in(irq_in), .trig_lvl(trig_lvl), .ack(ack),
  .int_out(int_out), .ack_vec(ack_vec), .irr_q(irr_q), .isr_q(isr_q),
  .imr_q(imr_q), .poll_q(poll_q), .aeoi_q(aeoi_q)
);

// File: tb/prio_intc_tb_top.sv
`timescale 1ns/1ps
module prio_intc_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0, irq_in = '0, trig_lvl = '0;
  logic [7:0] rdata, ack_vec;
  logic int_out;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  prio_intc dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .trig_lvl(trig_lvl),
    .int_out(int_out), .ack(ack), .ack_vec(ack_vec)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk); ack = 1'b1; #1 v = ack_vec;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk); #1;
  endtask

  task automatic reinit(input logic four, input logic [7:0] w4);
    trig_lvl = '0;
    set_irq(8'h00);
    wr(1'b0, {7'b0001000, four});
    wr(1'b1, 8'h4D);
    wr(1'b1, 8'h00);
    if (four) wr(1'b1, w4);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R5 reset output", int_out, 0);
    rd(1'b1, d); chk("R9 reset mask", d, 8'h00);
    rd(1'b0, d); chk("R9 reset request reg", d, 8'h00);
    do_ack(d); chk("R6 spurious vector after reset", d, 8'h07);
  endtask

  task automatic t_init;
    logic [7:0] d;
    wr(1'b0, 8'h10); wr(1'b1, 8'h4D); wr(1'b1, 8'h00); wr(1'b1, 8'h3C);
    rd(1'b1, d); chk("R4 three words then mask", d, 8'h3C);
    wr(1'b0, 8'h11); wr(1'b1, 8'h55); wr(1'b1, 8'h00); wr(1'b1, 8'h00); wr(1'b1, 8'hA5);
    rd(1'b1, d); chk("R4 four words then mask", d, 8'hA5);
    set_irq(8'h02);
    do_ack(d); chk("R3 base low bits zeroed", d, 8'h51);
  endtask

  task automatic t_edge;
    logic [7:0] d;
    reinit(1'b0, 8'h00);
    set_irq(8'h08);
    chk("R2 edge raises output", int_out, 1);
    do_ack(d); chk("R6 vector edge", d, 8'h4B);
    rd(1'b0, d); chk("R2 ack clears edge request", d, 8'h00);
    set_irq(8'h08);
    rd(1'b0, d); chk("R2 steady high no new request", d, 8'h00);
    set_irq(8'h00); set_irq(8'h08);
    rd(1'b0, d); chk("R2 new rise captured", d, 8'h08);
  endtask

  task automatic t_level;
    logic [7:0] d;
    reinit(1'b0, 8'h00);
    trig_lvl = 8'h10;
    set_irq(8'h10);
    rd(1'b0, d); chk("R1 level captured", d, 8'h10);
    do_ack(d); chk("R6 vector level", d, 8'h4C);
    rd(1'b0, d); chk("R1 ack keeps level request", d, 8'h10);
    set_irq(8'h00);
    rd(1'b0, d); chk("R1 level request drops", d, 8'h00);
  endtask

  task automatic t_prio_eoi;
    logic [7:0] d;
    reinit(1'b0, 8'h00);
    set_irq(8'h44);
    do_ack(d); chk("R5 lower level wins", d, 8'h4A);
    #1 chk("R5 in-service blocks lower", int_out, 0);
    set_irq(8'h46);
    chk("R5 higher preempts in-service", int_out, 1);
    do_ack(d); chk("R6 vector nested", d, 8'h49);
    wr(1'b0, 8'h0B); rd(1'b0, d); chk("R9 read in-service", d, 8'h06);
    wr(1'b0, 8'h20); rd(1'b0, d); chk("R8 nonspecific EOI", d, 8'h04);
    wr(1'b0, 8'h40); rd(1'b0, d); chk("R8 command 2 no effect", d, 8'h04);
    wr(1'b0, 8'h62); rd(1'b0, d); chk("R8 specific EOI", d, 8'h00);
    do_ack(d); chk("R8 pending released", d, 8'h4E);
  endtask

  task automatic t_rotate;
    logic [7:0] d;
    reinit(1'b0, 8'h00);
    wr(1'b0, 8'hC3);
    set_irq(8'h28);
    do_ack(d); chk("R8 set priority command", d, 8'h4D);
    wr(1'b0, 8'hA0);
    do_ack(d); chk("R8 rotate on EOI", d, 8'h4B);
    wr(1'b0, 8'hE3);
    wr(1'b0, 8'h0B); rd(1'b0, d); chk("R8 specific rotate clears", d, 8'h00);
    set_irq(8'h00); set_irq(8'h18);
    do_ack(d); chk("R8 specific rotate base", d, 8'h4C);
  endtask

  task automatic t_mask;
    logic [7:0] d;
    reinit(1'b0, 8'h00);
    wr(1'b1, 8'h08);
    set_irq(8'h08);
    chk("R5 masked request no output", int_out, 0);
    rd(1'b0, d); chk("R9 masked request still held", d, 8'h08);
    wr(1'b1, 8'h00); #1;
    chk("R5 unmask raises output", int_out, 1);
  endtask

  task automatic t_aeoi;
    logic [7:0] d;
    reinit(1'b1, 8'h02);
    set_irq(8'h04);
    do_ack(d); chk("R7 vector", d, 8'h4A);
    wr(1'b0, 8'h0B); rd(1'b0, d); chk("R7 no in-service", d, 8'h00);
    set_irq(8'h26);
    do_ack(d); chk("R7 no rotation by default", d, 8'h49);
    wr(1'b0, 8'h80);
    do_ack(d); chk("R7 vector with rotate", d, 8'h4D);
    set_irq(8'h00); set_irq(8'h81);
    do_ack(d); chk("R7 rotated past acknowledged", d, 8'h4F);
  endtask

  task automatic t_poll;
    logic [7:0] d;
    reinit(1'b0, 8'h00);
    set_irq(8'h48);
    wr(1'b0, 8'h0C); rd(1'b0, d); chk("R10 poll level", d, 8'h03);
    rd(1'b0, d); chk("R10 poll one-shot and clears", d, 8'h40);
    wr(1'b0, 8'h0C); rd(1'b0, d); chk("R10 poll next", d, 8'h06);
    wr(1'b0, 8'h0C); rd(1'b0, d); chk("R10 poll none", d, 8'h07);
    chk("R10 output low after polls", int_out, 0);
  endtask

  task automatic t_smask;
    logic [7:0] d;
    reinit(1'b0, 8'h00);
    set_irq(8'h04);
    do_ack(d);
    set_irq(8'h24);
    chk("R11 blocked without special mask", int_out, 0);
    wr(1'b1, 8'h04); #1;
    chk("R11 mask alone still blocks", int_out, 0);
    wr(1'b0, 8'h68); #1;
    chk("R11 special mask unblocks", int_out, 1);
    do_ack(d); chk("R11 vector", d, 8'h4D);
  endtask

  task automatic t_sfnm;
    logic [7:0] d;
    reinit(1'b1, 8'h10);
    set_irq(8'h04);
    do_ack(d); chk("R12 vector", d, 8'h4A);
    set_irq(8'h00); set_irq(8'h04);
    chk("R12 same input re-interrupts", int_out, 1);
  endtask

  task automatic t_spurious;
    logic [7:0] d;
    reinit(1'b0, 8'h00);
    do_ack(d); chk("R6 spurious vector", d, 8'h4F);
    wr(1'b0, 8'h0B); rd(1'b0, d); chk("R6 spurious no in-service", d, 8'h00);
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_init();
    t_edge();
    t_level();
    t_prio_eoi();
    t_rotate();
    t_mask();
    t_aeoi();
    t_poll();
    t_smask();
    t_sfnm();
    t_spurious();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule